// File: doc/BRIEF.md
# Saved-State Image Loader

This block rebuilds a processor's saved state from an image that arrives as a stream of bytes. Bytes come in over a valid/ready handshake. A marker flags the final byte. The block packs every three bytes into a 24-bit word, most significant byte first. The first six words form a header:

- Word 0 holds the instruction pointer.
- Word 1 holds the accumulator.
- Word 2 holds the return address.
- Word 3 holds the stack pointer.
- Word 4 holds the frame pointer.
- Word 5 is a spare slot and is thrown away.

Each word after the header is a memory word. These go out through a registered address/data/write-enable port, starting at address zero and rising by one with no gaps.

When an image ends with a legal length, the loader writes zero into every address the image did not supply, up to the last address of the memory. It holds off the input for the whole sweep, then pulses done. If the image is malformed, the loader pulses fail and reports a code naming the fault. The next byte after done or fail opens a fresh image.

Top module: `ldr_state_loader`

## Requirements
- R1: Bytes are taken only when inValid and inReady are both high. Idle gaps in inValid are allowed. Each three taken bytes form one word, the first byte in bits 23..16 and the third byte in bits 7..0. Word 0 loads pcOut, word 2 loads raOut, word 3 loads spOut and word 4 loads fpOut, each from bits 19..0 of its word. Word 1 loads all 24 bits into accOut.
- R2: Word 5 changes no register and produces no memory write.
- R3: The word with index 6+k is written to memory address k, for k = 0, 1, 2 and so on, in stream order.
- R4: After a stream with a legal length and no fault, every address from one past the last dump word up to MEM_WORDS-1 is written with zero. inReady stays low from the final byte until done has pulsed.
- R5: done is high for exactly one cycle, in the cycle right after the last memory write. errCode reads 0 while done is high.
- R6: A stream shorter than 15 bytes ends with a one-cycle fail pulse and errCode 3. It produces no done and no zero sweep.
- R7: A stream whose byte count is not a multiple of 3 ends with a fail pulse and errCode 2. The incomplete trailing word is not written.
- R8: If bits 23..20 are nonzero in word 0, 2, 3 or 4, the stream ends with a fail pulse and errCode 1. The accumulator word may use all 24 bits without error.
- R9: When several faults apply, errCode 3 wins over 2, and 2 wins over 1.
- R10: Dump words beyond address MEM_WORDS-1 are dropped. No write is ever issued to an address at or above MEM_WORDS.
- R11: The byte taken after a done or fail pulse is byte 0 of a new image, and the new image's dump starts again at address 0.
- R12: While reset is high and after it is released, inReady is 1, done, fail and memWe are 0, errCode is 0 and all register outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Byte on inData is offered |
| inReady | output | 1 | Loader can take a byte this cycle |
| inData | input | 8 | Stream byte |
| inLast | input | 1 | Offered byte is the final one of the image |
| pcOut | output | 20 | Restored instruction pointer |
| accOut | output | 24 | Restored accumulator |
| raOut | output | 20 | Restored return address |
| spOut | output | 20 | Restored stack pointer |
| fpOut | output | 20 | Restored frame pointer |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | 24 | Memory write data |
| done | output | 1 | One-cycle pulse: image fully loaded |
| fail | output | 1 | One-cycle pulse: image rejected |
| errCode | output | 2 | Fault code: 0 none, 1 upper bits, 2 length not multiple of 3, 3 too short |

## Verification
The hardest case to reach is two faults landing on the same final byte, because only the priority rule then decides the code. For example, a 13-byte stream whose first word carries nonzero upper bits is also short and also not a multiple of three. The bench builds such images byte by byte. In the same way it builds an image that overruns the memory, and a minimum-length 15-byte image whose final word has a faulty upper nibble. That last case is caught on the very byte that closes the stream. A reduced MEM_WORDS keeps the zero sweep short enough that every address can be inspected in a shadow memory.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int WORD_W = 24;
  localparam int PTR_W  = 20;
  localparam int MIN_WORDS = 5;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_HIGH_BITS = 2'd1,
    ERR_LEN_MOD3  = 2'd2,
    ERR_TOO_SHORT = 2'd3
  } errCode_t;

  typedef struct packed {
    logic take;    // accept the byte on the input
    logic fillWr;  // issue one zero write of the sweep
    logic clear;   // return counters to the start of an image
  } ctrlStrb_t;
endpackage

// File: rtl/ldr_dpath.sv
module ldr_dpath
  import ldr_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MEM_WORDS = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrb_t           strb,
  input  logic [7:0]          inData,
  output logic [PTR_W-1:0]    pcOut,
  output logic [WORD_W-1:0]   accOut,
  output logic [PTR_W-1:0]    raOut,
  output logic [PTR_W-1:0]    spOut,
  output logic [PTR_W-1:0]    fpOut,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_W-1:0]   memData,
  output logic                lenShort,
  output logic                lenOdd,
  output logic                hiErrAny,
  output logic                fillDone
);
  localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_WORDS);
  localparam logic [2:0] DUMP_IDX = 3'd6;

  logic [1:0]        byteIdx;
  logic [2:0]        wordIdx;   // saturates at DUMP_IDX
  logic [15:0]       hold;
  logic [ADDR_W:0]   nextAddr;
  logic              hiErr;
  logic [WORD_W-1:0] word;
  logic              wordDone, ptrSlot, hiBad, fits;

  assign word     = {hold, inData};
  assign wordDone = strb.take && (byteIdx == 2'd2);
  assign ptrSlot  = (wordIdx == 3'd0) || (wordIdx == 3'd2) ||
                    (wordIdx == 3'd3) || (wordIdx == 3'd4);
  assign hiBad    = wordDone && ptrSlot && (word[WORD_W-1:PTR_W] != '0);
  assign hiErrAny = hiErr || hiBad;
  assign lenOdd   = (byteIdx != 2'd2);
  assign lenShort = (wordIdx < 3'(MIN_WORDS - 1)) ||
                    ((wordIdx == 3'(MIN_WORDS - 1)) && (byteIdx != 2'd2));
  assign fits     = nextAddr < MEM_LIM;
  assign fillDone = !fits;

  always_ff @(posedge clk) begin
    if (rst) begin
      byteIdx  <= '0;
      wordIdx  <= '0;
      hold     <= '0;
      nextAddr <= '0;
      hiErr    <= 1'b0;
      pcOut    <= '0;
      accOut   <= '0;
      raOut    <= '0;
      spOut    <= '0;
      fpOut    <= '0;
      memWe    <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
    end else begin
      memWe <= 1'b0;
      if (strb.take) begin
        byteIdx <= (byteIdx == 2'd2) ? 2'd0 : byteIdx + 2'd1;
        hold    <= {hold[7:0], inData};
      end
      if (wordDone) begin
        hiErr <= hiErrAny;
        case (wordIdx)
          3'd0: pcOut  <= word[PTR_W-1:0];
          3'd1: accOut <= word;
          3'd2: raOut  <= word[PTR_W-1:0];
          3'd3: spOut  <= word[PTR_W-1:0];
          3'd4: fpOut  <= word[PTR_W-1:0];
          default: ;
        endcase
        if (wordIdx != DUMP_IDX) begin
          wordIdx <= wordIdx + 3'd1;
        end else if (fits) begin
          memWe    <= 1'b1;
          memAddr  <= nextAddr[ADDR_W-1:0];
          memData  <= word;
          nextAddr <= nextAddr + 1'b1;
        end
      end
      if (strb.fillWr && fits) begin
        memWe    <= 1'b1;
        memAddr  <= nextAddr[ADDR_W-1:0];
        memData  <= '0;
        nextAddr <= nextAddr + 1'b1;
      end
      if (strb.clear) begin
        byteIdx  <= '0;
        wordIdx  <= '0;
        nextAddr <= '0;
        hiErr    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import ldr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  input  logic      inLast,
  output logic      inReady,
  input  logic      lenShort,
  input  logic      lenOdd,
  input  logic      hiErrAny,
  input  logic      fillDone,
  output ctrlStrb_t strb,
  output logic      done,
  output logic      fail,
  output errCode_t  errCode
);
  typedef enum logic {S_LOAD, S_FILL} state_t;
  state_t state;
  logic take, closing;
  errCode_t verdict;

  assign inReady = (state == S_LOAD);
  assign take    = inValid && inReady;
  assign closing = take && inLast;

  always_comb begin
    if (lenShort)      verdict = ERR_TOO_SHORT;
    else if (lenOdd)   verdict = ERR_LEN_MOD3;
    else if (hiErrAny) verdict = ERR_HIGH_BITS;
    else               verdict = ERR_NONE;
  end

  always_comb begin
    strb        = '0;
    strb.take   = take;
    strb.fillWr = (state == S_FILL) && !fillDone;
    strb.clear  = (closing && verdict != ERR_NONE) ||
                  ((state == S_FILL) && fillDone);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_LOAD;
      done    <= 1'b0;
      fail    <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      if (closing) begin
        if (verdict != ERR_NONE) begin
          fail    <= 1'b1;
          errCode <= verdict;
        end else begin
          state <= S_FILL;
        end
      end
      if (state == S_FILL && fillDone) begin
        done    <= 1'b1;
        errCode <= ERR_NONE;
        state   <= S_LOAD;
      end
    end
  end
endmodule

// File: rtl/ldr_state_loader.sv
module ldr_state_loader
  import ldr_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int MEM_WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inLast,
  output logic [19:0]       pcOut,
  output logic [23:0]       accOut,
  output logic [19:0]       raOut,
  output logic [19:0]       spOut,
  output logic [19:0]       fpOut,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [23:0]       memData,
  output logic              done,
  output logic              fail,
  output logic [1:0]        errCode
);
  ctrlStrb_t strb;
  errCode_t  code;
  logic lenShort, lenOdd, hiErrAny, fillDone;

  assign errCode = code;

  ldr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .lenShort(lenShort), .lenOdd(lenOdd),
    .hiErrAny(hiErrAny), .fillDone(fillDone), .strb(strb),
    .done(done), .fail(fail), .errCode(code)
  );

  ldr_dpath #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .inData(inData),
    .pcOut(pcOut), .accOut(accOut), .raOut(raOut), .spOut(spOut),
    .fpOut(fpOut), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .lenShort(lenShort), .lenOdd(lenOdd), .hiErrAny(hiErrAny),
    .fillDone(fillDone)
  );
endmodule

// File: rtl/ldr_state_loader_chk.sv
module ldr_state_loader_chk #(
  parameter int ADDR_W    = 20,
  parameter int MEM_WORDS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              inReady,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [23:0]       memData,
  input logic              done,
  input logic              fail,
  input logic [1:0]        errCode
);
  // R5
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (errCode == 2'd0) && !fail);

  // R6
  fail_coded_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> (errCode != 2'd0));

  // R4
  sweep_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (memWe && $past(!inReady)) |-> (memData == 24'd0));

  // R5
  done_after_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(!inReady) && !memWe);

  // R10
  addr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    memWe |-> ({1'b0, memAddr} < (ADDR_W+1)'(MEM_WORDS)));

  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> !done && !fail && !memWe);
endmodule

bind ldr_state_loader ldr_state_loader_chk #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_chk (
  .clk(clk), .rst(rst), .inReady(inReady), .memWe(memWe), .memAddr(memAddr),
  .memData(memData), .done(done), .fail(fail), .errCode(errCode)
);

// File: tb/sim_ldr_state_loader.sv
module sim_ldr_state_loader;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int MW = 40;
  localparam logic [23:0] SENT = 24'hA5A5A5;

  logic clk = 1'b0, rst = 1'b1;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [7:0] inData = '0;
  logic inReady, memWe, done, fail;
  logic [19:0] pcOut, raOut, spOut, fpOut;
  logic [23:0] accOut, memData;
  logic [AW-1:0] memAddr;
  logic [1:0] errCode;

  int tests = 0, fails = 0;
  int cyc = 0, doneCnt = 0, failCnt = 0, lowCnt = 0, lastWe = 0, doneCyc = 0, oobCnt = 0;
  logic [23:0] mem [0:(1<<AW)-1];
  logic [7:0] img [0:255];
  int imgLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldr_state_loader #(.ADDR_W(AW), .MEM_WORDS(MW)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .pcOut(pcOut), .accOut(accOut), .raOut(raOut), .spOut(spOut),
    .fpOut(fpOut), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .done(done), .fail(fail), .errCode(errCode)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (memWe) begin
        mem[memAddr] <= memData;
        lastWe <= cyc;
        if (int'(memAddr) >= MW) oobCnt <= oobCnt + 1;
      end
      if (done) begin doneCnt <= doneCnt + 1; doneCyc <= cyc; end
      if (fail) failCnt <= failCnt + 1;
      if (!inReady) lowCnt <= lowCnt + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prep();
    @(negedge clk);
    for (int i = 0; i < (1<<AW); i++) mem[i] = SENT;
    doneCnt = 0; failCnt = 0; lowCnt = 0; oobCnt = 0;
    imgLen = 0;
  endtask

  task automatic addWord(logic [23:0] w);
    img[imgLen] = w[23:16]; img[imgLen+1] = w[15:8]; img[imgLen+2] = w[7:0];
    imgLen += 3;
  endtask

  task automatic addHeader(logic [23:0] p, logic [23:0] a, logic [23:0] r,
                           logic [23:0] s, logic [23:0] f);
    addWord(p); addWord(a); addWord(r); addWord(s); addWord(f);
  endtask

  task automatic sendImage(bit gaps);
    for (int i = 0; i < imgLen; i++) begin
      if (gaps && (i % 4 == 1)) begin
        @(negedge clk); inValid = 1'b0;
        @(negedge clk);
      end else begin
        @(negedge clk);
      end
      inValid = 1'b1; inData = img[i]; inLast = (i == imgLen - 1);
      #1;
      while (!inReady) begin @(negedge clk); #1; end
    end
    @(negedge clk); inValid = 1'b0; inLast = 1'b0;
    for (int k = 0; k < 200 && doneCnt == 0 && failCnt == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12 ready", inReady, 1); chk("R12 done", done, 0); chk("R12 fail", fail, 0);
    chk("R12 memWe", memWe, 0); chk("R12 code", errCode, 0);
    chk("R12 pc", pcOut, 0); chk("R12 acc", accOut, 0);
  endtask

  task automatic t_basic();
    prep();
    addHeader(24'h0ABCDE, 24'hF12345, 24'h054321, 24'h0FFFFF, 24'h000010);
    addWord(24'h777777);
    addWord(24'h111111); addWord(24'h800000); addWord(24'hFEDCBA);
    sendImage(1'b1);
    chk("R1 pc", pcOut, 20'hABCDE); chk("R1 acc", accOut, 24'hF12345);
    chk("R1 ra", raOut, 20'h54321); chk("R1 sp", spOut, 20'hFFFFF);
    chk("R1 fp", fpOut, 20'h00010);
    chk("R3 m0", mem[0], 24'h111111); chk("R3 m1", mem[1], 24'h800000);
    chk("R3 m2", mem[2], 24'hFEDCBA);
    begin
      int bad = 0;
      for (int a = 3; a < MW; a++) if (mem[a] !== 24'd0) bad++;
      chk("R4 zero sweep", bad, 0);
    end
    chk("R4 ready low cycles", lowCnt, MW - 3 + 1);
    chk("R5 done count", doneCnt, 1); chk("R5 done timing", doneCyc, lastWe + 1);
    chk("R5 code", errCode, 0); chk("R5 no fail", failCnt, 0);
  endtask

  task automatic t_spare();
    prep();
    addHeader(24'h000001, 24'h000002, 24'h000003, 24'h000004, 24'h000005);
    addWord(24'h123456);
    sendImage(1'b0);
    chk("R2 m0 zero", mem[0], 24'd0); chk("R2 fp kept", fpOut, 20'h5);
    chk("R2 acc kept", accOut, 24'h2); chk("R2 done", doneCnt, 1);
  endtask

  task automatic t_min();
    prep();
    addHeader(24'h00000A, 24'h00000B, 24'h00000C, 24'h00000D, 24'h00000E);
    sendImage(1'b0);
    chk("R1 min pc", pcOut, 20'hA); chk("R4 min ready low", lowCnt, MW + 1);
    chk("R4 min last addr", mem[MW-1], 24'd0); chk("R5 min done", doneCnt, 1);
  endtask

  task automatic t_short();
    prep();
    addWord(24'h1); addWord(24'h2); addWord(24'h3); addWord(24'h4);
    sendImage(1'b0);
    chk("R6 fail", failCnt, 1); chk("R6 code", errCode, 3);
    chk("R6 no done", doneCnt, 0); chk("R6 no sweep", mem[0], SENT);
    chk("R6 no ready low", lowCnt, 0);
  endtask

  task automatic t_mod3();
    prep();
    addHeader(24'h1, 24'h2, 24'h3, 24'h4, 24'h5);
    addWord(24'h0); addWord(24'h222222);
    imgLen -= 1;
    sendImage(1'b0);
    chk("R7 fail", failCnt, 1); chk("R7 code", errCode, 2);
    chk("R7 partial unwritten", mem[0], SENT); chk("R7 no done", doneCnt, 0);
  endtask

  task automatic t_high();
    prep();
    addHeader(24'h1, 24'hFFFFFF, 24'h3, 24'h4, 24'h100005);
    sendImage(1'b0);
    chk("R8 fail", failCnt, 1); chk("R8 code", errCode, 1);
    chk("R8 acc full width", accOut, 24'hFFFFFF); chk("R8 no done", doneCnt, 0);
    prep();
    addHeader(24'h1, 24'hF00000, 24'h3, 24'h4, 24'h5);
    sendImage(1'b0);
    chk("R8 acc upper allowed", doneCnt, 1); chk("R8 code 0", errCode, 0);
  endtask

  task automatic t_prio();
    prep();
    addWord(24'hF00000); addWord(24'h2); addWord(24'h3); addWord(24'h4);
    imgLen = 13;
    sendImage(1'b0);
    chk("R9 short wins", errCode, 3);
    prep();
    addHeader(24'h1, 24'h2, 24'hF00003, 24'h4, 24'h5);
    addWord(24'h6);
    imgLen = 17;
    sendImage(1'b0);
    chk("R9 mod3 over high", errCode, 2);
  endtask

  task automatic t_overrun();
    prep();
    addHeader(24'h1, 24'h2, 24'h3, 24'h4, 24'h5);
    addWord(24'h0);
    for (int k = 0; k < MW + 2; k++) addWord(24'h100 + 24'(k));
    sendImage(1'b0);
    chk("R10 last kept", mem[MW-1], 24'h100 + 24'(MW-1));
    chk("R10 no oob", oobCnt, 0); chk("R10 beyond untouched", mem[MW], SENT);
    chk("R10 done", doneCnt, 1);
  endtask

  task automatic t_restart();
    prep();
    addWord(24'h1);
    sendImage(1'b0);
    chk("R11 fail first", failCnt, 1);
    prep();
    addHeader(24'h00ABC, 24'h2, 24'h3, 24'h4, 24'h5);
    addWord(24'h0); addWord(24'h55AA55);
    sendImage(1'b0);
    chk("R11 fresh pc", pcOut, 20'hABC); chk("R11 addr0", mem[0], 24'h55AA55);
    chk("R11 done", doneCnt, 1);
    prep();
    addHeader(24'h00DEF, 24'h2, 24'h3, 24'h4, 24'h5);
    addWord(24'h0); addWord(24'h0F0F0F);
    sendImage(1'b0);
    chk("R11 after done pc", pcOut, 20'hDEF); chk("R11 after done addr0", mem[0], 24'h0F0F0F);
  endtask

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = SENT;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_spare();
    t_min();
    t_short();
    t_mod3();
    t_high();
    t_prio();
    t_overrun();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule